// File: doc/BRIEF.md
# Segment Register with Load-Time Descriptor Checks

This block is one segment register of an address-generation path. It has two parts. The visible part is a 16-bit selector that software writes. The hidden part is a cached copy of the selected segment's descriptor: base, limit, code/data type and a valid flag.

Writing a selector starts a hardware fetch of the 8-byte descriptor, in two 32-bit reads. The reads go through a simple request/acknowledge memory port to either the global or the local descriptor table. If the descriptor says the segment is present, the hidden part and the visible selector are replaced together. If it says the segment is absent, a not-present fault is reported and both parts keep their old contents.

After a load, every access presents a 16-bit offset and a kind (read, write or instruction fetch). The access is checked against the cached descriptor without touching memory. It is answered one cycle later with a fault cause or with the linear address, which is base plus offset. While a descriptor load is in flight, accesses are held off with a ready signal.

Top module: `seg_unit`

## Requirements
- R1: After reset, `sel_out` is 0, `busy` is 0, `acc_ready` is 1, and `load_done`, `np_fault` and `res_valid` are 0. No segment is loaded.
- R2: A write of `sel_wdata` while `busy` is 0 starts a load, and `busy` is 1 in the next cycle. Selector bits [15:3] are the descriptor index and bit 2 picks the table (0 = global at `GTBL_BASE`, 1 = local at `LTBL_BASE`). Bits [1:0] are ignored. The two reads use the addresses table base + index*8 and that address + 4.
- R3: `mem_req` stays asserted with a stable `mem_addr` until `mem_ack` is seen. `mem_rdata` is taken in the cycle of `mem_ack`. Each load makes exactly two reads: the low word first, then the high word.
- R4: Descriptor layout. Low word: [15:0] limit, [31:16] base[15:0]. High word: [7:0] base[23:16], [8] present, [9] code type (1 = code, 0 = data). All other bits are ignored.
- R5: When a load of a present descriptor ends, `load_done` pulses for one cycle, `np_fault` stays 0, and `sel_out` and the cached descriptor take the new values in that same cycle.
- R6: When a load of an absent descriptor ends, `load_done` and `np_fault` pulse together. `sel_out` and the cached descriptor keep their previous values, so later accesses still use the old segment.
- R7: An access with an offset strictly greater than the cached limit faults with cause 1 (limit). An offset equal to the limit is allowed.
- R8: Access kind encoding: 0 = read, 1 = write, 2 = instruction fetch, 3 = read. A fetch from a data segment, or a write to a code segment, faults with cause 2 (type). Reads are allowed on both types. When both checks fail, the limit fault wins.
- R9: An accepted access gives `res_valid` in the next cycle. With no fault, `res_fault` is 0, `res_cause` is 0 and `lin_addr` is (base + offset) mod 2^24. With a fault, `res_fault` is 1 and `lin_addr` is 0.
- R10: An access made before any successful load faults with cause 3 (no segment), whatever its kind or offset.
- R11: While `busy` is 1, `acc_ready` is 0 and accesses are stalled. Selector writes are ignored: the load in flight and its final `sel_out` are unaffected. A stalled access is answered against the newly loaded descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_wdata | input | 16 | Selector value to load |
| sel_out | output | 16 | Visible selector of the loaded segment |
| busy | output | 1 | Descriptor load in progress |
| load_done | output | 1 | One-cycle pulse at the end of a load |
| np_fault | output | 1 | One-cycle pulse: the loaded descriptor was absent |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 24 | Byte address of the descriptor word |
| mem_ack | input | 1 | Read acknowledge, with data valid |
| mem_rdata | input | 32 | Read data |
| acc_valid | input | 1 | Access request |
| acc_kind | input | 2 | Access kind (R8 encoding) |
| acc_off | input | 16 | Access offset |
| acc_ready | output | 1 | Access accepted this cycle when high |
| res_valid | output | 1 | Access result valid |
| res_fault | output | 1 | Access faulted |
| res_cause | output | 2 | 0 none, 1 limit, 2 type, 3 no segment |
| lin_addr | output | 24 | Linear address, 0 on fault |

## Verification
A wrong cached descriptor shows up in the first access after the load. A wrong base changes `lin_addr`. A wrong limit moves the boundary at which cause 1 appears. A wrong type flag swaps which of write and fetch gives cause 2. A hidden part that was wrongly updated by an absent load shows up on the very next access as the new segment's values, and `sel_out` shows the error in the cycle of `load_done`. A fault in the fetch sequencer shows as wrong data, and so as wrong addresses and limits, or as a load that never completes; the sweep over both tables, with indices at the low and high ends, brings these out.

// File: rtl/seg_pkg.sv
// Package: shared constants, encodings and the descriptor record for the
// segment register unit. Assumes a 16-bit selector and 32-bit memory words.
package seg_pkg;
    localparam int SEL_W    = 16;
    localparam int IDX_W    = 13;
    localparam int IDX_LSB  = 3;
    localparam int TSEL_BIT = 2;
    localparam int OFF_W    = 16;
    localparam int WORD_W   = 32;
    localparam int BASE_W   = 24;
    localparam int LIM_W    = 16;
    localparam int HI_WORD_STEP = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_LIMIT = 2'd1,
        CAUSE_TYPE  = 2'd2,
        CAUSE_NOSEG = 2'd3
    } cause_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              present;
        logic              code;
    } desc_t;

    // Decode the two descriptor words into the cached record.
    function automatic desc_t desc_unpack(logic [WORD_W-1:0] lo, logic [WORD_W-1:0] hi);
        desc_t d;
        d.base    = {hi[7:0], lo[31:16]};
        d.limit   = lo[15:0];
        d.present = hi[8];
        d.code    = hi[9];
        return d;
    endfunction
endpackage

// File: rtl/seg_desc_fetch.sv
// Descriptor fetch sequencer and hidden descriptor store.
// On start it reads two 32-bit words (low, then high) from the table picked
// by the selector, then commits selector and descriptor only if present.
// Assumes memory holds mem_addr stable data valid in the mem_ack cycle.
module seg_desc_fetch
    import seg_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] GTBL_BASE = '0,
    parameter logic [ADDR_W-1:0] LTBL_BASE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [SEL_W-1:0]     sel_in,
    output logic                 busy,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 load_done,
    output logic                 np_fault,
    output logic [SEL_W-1:0]     sel_vis,
    output logic                 hid_valid,
    output logic [BASE_W-1:0]    hid_base,
    output logic [LIM_W-1:0]     hid_limit,
    output logic                 hid_code
);
    typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fst_e;

    localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(HI_WORD_STEP);

    fst_e               st;
    logic [SEL_W-1:0]   pend_sel;
    logic [WORD_W-1:0]  lo_q;
    desc_t              new_desc;
    logic [ADDR_W-1:0]  tbl_base;
    logic [ADDR_W-1:0]  ent_off;

    // Decode the incoming descriptor from the held low word and the live high word.
    assign new_desc = desc_unpack(lo_q, mem_rdata);

    // Form the descriptor word address from table select, index and word step.
    always_comb begin
        tbl_base = pend_sel[TSEL_BIT] ? LTBL_BASE : GTBL_BASE;
        ent_off  = ADDR_W'({pend_sel[SEL_W-1:IDX_LSB], 3'b000});
        mem_addr = tbl_base + ent_off + ((st == F_HI) ? HI_STEP : '0);
    end

    assign busy    = (st != F_IDLE);
    assign mem_req = busy;

    // Sequence the two reads and commit the descriptor at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= F_IDLE;
            pend_sel  <= '0;
            lo_q      <= '0;
            load_done <= 1'b0;
            np_fault  <= 1'b0;
            sel_vis   <= '0;
            hid_valid <= 1'b0;
            hid_base  <= '0;
            hid_limit <= '0;
            hid_code  <= 1'b0;
        end else begin
            load_done <= 1'b0;
            np_fault  <= 1'b0;
            case (st)
                F_IDLE: begin
                    if (start) begin
                        pend_sel <= sel_in;
                        st       <= F_LO;
                    end
                end
                F_LO: begin
                    if (mem_ack) begin
                        lo_q <= mem_rdata;
                        st   <= F_HI;
                    end
                end
                F_HI: begin
                    if (mem_ack) begin
                        st        <= F_IDLE;
                        load_done <= 1'b1;
                        if (new_desc.present) begin
                            sel_vis   <= pend_sel;
                            hid_valid <= 1'b1;
                            hid_base  <= new_desc.base;
                            hid_limit <= new_desc.limit;
                            hid_code  <= new_desc.code;
                        end else begin
                            np_fault <= 1'b1;
                        end
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seg_access_check.sv
// Per-access checker: compares the offset and kind with the cached
// descriptor and registers the verdict and the linear address.
// Assumes the cached descriptor is stable whenever fire is high.
module seg_access_check
    import seg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [1:0]         kind,
    input  logic [OFF_W-1:0]   off,
    input  logic               hid_valid,
    input  logic [BASE_W-1:0]  hid_base,
    input  logic [LIM_W-1:0]   hid_limit,
    input  logic               hid_code,
    output logic               res_valid,
    output logic               res_fault,
    output logic [1:0]         res_cause,
    output logic [BASE_W-1:0]  res_lin
);
    logic              over_lim;
    logic              bad_type;
    cause_e            cause;
    logic [BASE_W-1:0] sum;

    // Classify the access; absence beats limit, limit beats type.
    always_comb begin
        over_lim = ({{(LIM_W > OFF_W ? LIM_W - OFF_W : 0){1'b0}}, off} > hid_limit);
        bad_type = ((acc_kind_e'(kind) == ACC_FETCH) && !hid_code) ||
                   ((acc_kind_e'(kind) == ACC_WRITE) &&  hid_code);
        if (!hid_valid)    cause = CAUSE_NOSEG;
        else if (over_lim) cause = CAUSE_LIMIT;
        else if (bad_type) cause = CAUSE_TYPE;
        else               cause = CAUSE_NONE;
        sum = hid_base + BASE_W'(off);
    end

    // Register the verdict one cycle after the access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_fault <= 1'b0;
            res_cause <= CAUSE_NONE;
            res_lin   <= '0;
        end else begin
            res_valid <= fire;
            if (fire) begin
                res_cause <= cause;
                res_fault <= (cause != CAUSE_NONE);
                res_lin   <= (cause == CAUSE_NONE) ? sum : '0;
            end
        end
    end
endmodule

// File: rtl/seg_unit.sv
// Top of the segment register unit: visible selector plus hidden descriptor,
// loaded through the memory read port, then used to check each access.
// Assumes the table bases leave room for 8192 eight-byte entries.
module seg_unit
    import seg_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] GTBL_BASE = 24'h010000,
    parameter logic [ADDR_W-1:0] LTBL_BASE = 24'h200000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_wr,
    input  logic [15:0]         sel_wdata,
    output logic [15:0]         sel_out,
    output logic                busy,
    output logic                load_done,
    output logic                np_fault,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [31:0]         mem_rdata,
    input  logic                acc_valid,
    input  logic [1:0]          acc_kind,
    input  logic [15:0]         acc_off,
    output logic                acc_ready,
    output logic                res_valid,
    output logic                res_fault,
    output logic [1:0]          res_cause,
    output logic [23:0]         lin_addr
);
    logic              start;
    logic              fire;
    logic              hid_valid;
    logic [BASE_W-1:0] hid_base;
    logic [LIM_W-1:0]  hid_limit;
    logic              hid_code;

    // Accept selector writes and accesses only when no load is in flight.
    assign start     = sel_wr && !busy;
    assign acc_ready = !busy;
    assign fire      = acc_valid && acc_ready;

    seg_desc_fetch #(
        .ADDR_W    (ADDR_W),
        .GTBL_BASE (GTBL_BASE),
        .LTBL_BASE (LTBL_BASE)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sel_in    (sel_wdata),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .load_done (load_done),
        .np_fault  (np_fault),
        .sel_vis   (sel_out),
        .hid_valid (hid_valid),
        .hid_base  (hid_base),
        .hid_limit (hid_limit),
        .hid_code  (hid_code)
    );

    seg_access_check u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .kind      (acc_kind),
        .off       (acc_off),
        .hid_valid (hid_valid),
        .hid_base  (hid_base),
        .hid_limit (hid_limit),
        .hid_code  (hid_code),
        .res_valid (res_valid),
        .res_fault (res_fault),
        .res_cause (res_cause),
        .res_lin   (lin_addr)
    );
endmodule

// File: rtl/seg_unit_chk.sv
// Property checker for seg_unit, attached by bind below.
module seg_unit_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              load_done,
    input logic              np_fault,
    input logic [15:0]       sel_out,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              res_valid,
    input logic              res_fault,
    input logic [1:0]        res_cause,
    input logic [23:0]       lin_addr
);
    // R3: request held with a steady address until acknowledged
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5: load completion leaves the unit idle
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !busy);

    // R6: absent descriptor never changes the visible selector
    a_r6_np_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        np_fault |-> (load_done && $stable(sel_out)));

    // R9: a faulted access never exposes an address
    a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (lin_addr == 24'h0));

    // R9: fault flag agrees with the cause code
    a_r9_cause_flag: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_fault == (res_cause != 2'd0)));

    // R11: no access result follows a busy cycle
    a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$past(busy));
endmodule

bind seg_unit seg_unit_chk #(.ADDR_W(ADDR_W)) u_seg_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .load_done (load_done),
    .np_fault  (np_fault),
    .sel_out   (sel_out),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .res_cause (res_cause),
    .lin_addr  (lin_addr)
);

// File: tb/tb_seg_unit.sv
module tb_seg_unit;
    localparam logic [23:0] GT = 24'h010000;
    localparam logic [23:0] LT = 24'h200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [15:0] sel_wdata = '0;
    logic [15:0] sel_out;
    logic        busy, load_done, np_fault, mem_req;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [15:0] acc_off = '0;
    logic        acc_ready, res_valid, res_fault;
    logic [1:0]  res_cause;
    logic [23:0] lin_addr;

    int total = 0;
    int bad = 0;
    int acks = 0;
    int cnt = 0;
    bit finished = 0;

    logic        e_valid = 0;
    logic [23:0] e_base = 0;
    logic [15:0] e_lim = 0;
    logic        e_code = 0;
    logic [15:0] e_sel = 0;

    always #2 clk = ~clk;

    seg_unit #(.ADDR_W(24), .GTBL_BASE(GT), .LTBL_BASE(LT)) dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .sel_out(sel_out), .busy(busy), .load_done(load_done), .np_fault(np_fault),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_off(acc_off), .acc_ready(acc_ready),
        .res_valid(res_valid), .res_fault(res_fault), .res_cause(res_cause), .lin_addr(lin_addr));

    function automatic logic [15:0] m_lim(int t, int i);
        return 16'(i * 733 + t * 97 + 5);
    endfunction
    function automatic logic [23:0] m_base(int t, int i);
        return 24'(i * 41395 + t * 1193047);
    endfunction
    function automatic logic m_pres(int i);
        return (i % 4) != 3;
    endfunction
    function automatic logic m_code(int i);
        return (i % 3) == 0;
    endfunction

    // Descriptor memory: R4 layout, R2 addressing.
    function automatic logic [31:0] mem_word(logic [23:0] a);
        int t, o, i;
        logic [23:0] b;
        t = (a >= LT) ? 1 : 0;
        o = int'(a - (t ? LT : GT));
        i = o >> 3;
        b = m_base(t, i);
        if (((o >> 2) & 1) == 0) return {b[15:0], m_lim(t, i)};
        return {22'h2AAAA, m_code(i), m_pres(i), b[23:16]} & 32'hFFC0_03FF | 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            cnt <= 0;
        end else if (mem_req) begin
            if (cnt == 2) begin
                mem_ack <= 1'b1;
                mem_rdata <= mem_word(mem_addr);
                acks <= acks + 1;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_cause(logic [1:0] k, logic [15:0] off);
        if (!e_valid) return 2'd3;
        if (off > e_lim) return 2'd1;
        if ((k == 2'd2 && !e_code) || (k == 2'd1 && e_code)) return 2'd2;
        return 2'd0;
    endfunction

    task automatic do_access(logic [1:0] k, logic [15:0] off, string req);
        logic [1:0] ec;
        ec = exp_cause(k, off);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = k; acc_off = off;
        while (!acc_ready) @(negedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        chk(res_valid === 1'b1, req, res_valid, 1);
        chk(res_cause === ec, req, res_cause, ec);
        chk(res_fault === (ec != 0), req, res_fault, ec != 0);
        chk(lin_addr === ((ec == 0) ? 24'(e_base + off) : 24'h0), req, lin_addr,
            (ec == 0) ? 24'(e_base + off) : 24'h0);
    endtask

    task automatic do_load(logic [15:0] s);
        int t, i, n;
        t = s[2]; i = s[15:3];
        @(negedge clk);
        sel_wr = 1'b1; sel_wdata = s; acks = 0;
        @(negedge clk);
        sel_wr = 1'b0;
        chk(busy === 1'b1, "R2 busy after write", busy, 1);
        n = 0;
        while (!load_done && n < 100) begin @(negedge clk); n++; end
        chk(load_done === 1'b1, "R5 load_done", load_done, 1);
        chk(np_fault === !m_pres(i), "R6 np_fault", np_fault, !m_pres(i));
        chk(acks == 2, "R3 two reads", acks, 2);
        if (m_pres(i)) begin
            e_valid = 1; e_base = m_base(t, i); e_lim = m_lim(t, i);
            e_code = m_code(i); e_sel = s;
        end
        chk(sel_out === e_sel, "R5 R6 sel_out", sel_out, e_sel);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(sel_out === 16'h0, "R1 sel_out", sel_out, 0);
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(acc_ready === 1'b1, "R1 acc_ready", acc_ready, 1);
        chk(load_done === 1'b0 && np_fault === 1'b0, "R1 pulses", {load_done, np_fault}, 0);
        chk(res_valid === 1'b0, "R1 res_valid", res_valid, 0);
        rst_n = 1'b1;
        // R10: no segment yet
        for (int k = 0; k < 4; k++) do_access(2'(k), 16'(k * 1000), "R10 no segment");
        // R2..R9 sweep over both tables, low and high indices
        for (int t = 0; t < 2; t++) begin
            for (int q = 0; q < 12; q++) begin
                int i;
                i = (q < 10) ? q : 8180 + q;
                do_load({13'(i), 1'(t), 2'(q & 3)});
                for (int j = 0; j < 6; j++) begin
                    logic [15:0] off;
                    case (j)
                        0: off = 16'h0;
                        1: off = e_lim - 16'd1;
                        2: off = e_lim;
                        3: off = e_lim + 16'd1;
                        4: off = e_lim >> 1;
                        default: off = 16'hFFFF;
                    endcase
                    for (int k = 0; k < 4; k++)
                        do_access(2'(k), off, "R7 R8 R9 access sweep");
                end
            end
        end
        // R11: stall during load, selector write ignored while busy
        begin
            int n;
            logic [15:0] sa;
            sa = {13'd12, 1'b1, 2'b00};
            @(negedge clk);
            sel_wr = 1'b1; sel_wdata = sa;
            @(negedge clk);
            sel_wdata = {13'd6, 1'b0, 2'b00};
            acc_valid = 1'b1; acc_kind = 2'd0; acc_off = 16'd0;
            chk(acc_ready === 1'b0, "R11 ready low", acc_ready, 0);
            @(negedge clk);
            sel_wr = 1'b0;
            n = 0;
            while (!load_done && n < 100) begin
                chk(acc_ready === 1'b0 && res_valid === 1'b0, "R11 stalled", {acc_ready, res_valid}, 0);
                @(negedge clk); n++;
            end
            e_valid = 1; e_base = m_base(1, 12); e_lim = m_lim(1, 12); e_code = m_code(12); e_sel = sa;
            chk(sel_out === sa, "R11 ignored write", sel_out, sa);
            @(negedge clk);
            acc_valid = 1'b0;
            chk(res_valid === 1'b1 && lin_addr === e_base, "R11 stalled access result", lin_addr, e_base);
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule